// File: doc/BRIEF.md
# Interrupt Mask and Priority Controller

This block holds the two interrupt-mask flags of a small 8-bit CPU's condition code register. One flag, X, gates the nonmaskable request line. The other flag, I, gates every ordinary request. The X flag is one-way. After reset both flags are set. Software may clear X once, and after that no software write can set it again. From then on the nonmaskable line cannot be masked by software.

At each instruction boundary the CPU sequencer raises a strobe. On that strobe the block looks at three kinds of request:

- an illegal-opcode trap, which is never gated;
- the nonmaskable pin, gated by X;
- a vector of maskable lines, gated by I and ranked by fixed priority.

In the next cycle the block reports whether an interrupt is to be taken and which source won. The sequencer then stacks the condition code byte and pulses an entry strobe. On that strobe the flags are raised as the kind of entry requires. A return-from-interrupt strobe carries the unstacked byte, and the flags are reloaded from it.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is active and after its release, X=1, I=1 and take=0.
- R2: A software write with wr_x=0 clears X. A software write with wr_x=1 leaves X at its current value. Once X has been 0, no software write sets it.
- R3: A software write loads I from wr_i and has no effect on X.
- R4: An illegal-opcode request at a boundary is taken whatever the values of X and I, with source id 0. It ranks above the nonmaskable request.
- R5: A nonmaskable request at a boundary is taken with source id 1 when X=0, and it beats every maskable line. When X=1 it is ignored.
- R6: Maskable line k is taken with source id 2+k only when I=0 and no trap or unmasked nonmaskable request is present. The lowest set index wins.
- R7: A maskable-entry strobe sets I and leaves X unchanged.
- R8: A nonmaskable-entry strobe sets both X and I.
- R9: A return strobe loads I from rti_i. It loads X from rti_x, except that a restored 1 cannot set X once X has been 0.
- R10: take is high for exactly the one cycle after a boundary strobe that found an eligible request, and is never high otherwise. src is valid while take is high.
- R11: When strobes coincide, the flag update follows the order: nonmaskable entry, then maskable entry, then return, then software write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software write to the condition code register |
| sw_x | input | 1 | X value carried by the write |
| sw_i | input | 1 | I value carried by the write |
| ent_mask | input | 1 | Entry strobe for a maskable or trap interrupt |
| ent_nmi | input | 1 | Entry strobe for a nonmaskable interrupt |
| rti_en | input | 1 | Return-from-interrupt strobe |
| rti_x | input | 1 | X value from the unstacked byte |
| rti_i | input | 1 | I value from the unstacked byte |
| bnd | input | 1 | Instruction boundary sample strobe |
| trap_req | input | 1 | Illegal-opcode trap request |
| nmi_req | input | 1 | Nonmaskable request level |
| irq_req | input | NUM_IRQ | Maskable request lines, index 0 highest |
| x_flag | output | 1 | Nonmaskable mask flag |
| i_flag | output | 1 | General mask flag |
| take | output | 1 | Take-interrupt pulse |
| src | output | SRC_W | Winning source id |

## Verification
The bench tries to set X by software both before and after X has first been cleared. A design that lets X rise again would let the nonmaskable line be masked. The bench also returns from a nonmaskable handler with a restored X of 1 after the unlock. A design that reloads X blindly would re-mask the pin. Priority is tested by presenting the trap, the nonmaskable request and several maskable lines together under different flag values. A wrong ranking shows up as a wrong source id, and a wrong gate shows up as a take where none is allowed. The single-cycle take is checked by holding requests high without a boundary strobe. Coincident entry and return strobes check the update order, which a design with the wrong order would leave with I or X cleared.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned SRC_TRAP      = 0;
  localparam int unsigned SRC_NMI       = 1;
  localparam int unsigned SRC_MASK_BASE = 2;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N-1:0] grant;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_grant
      if (k == 0) begin : g_top
        assign grant[k] = req[k];
      end else begin : g_rest
        assign grant[k] = req[k] & ~(|req[k-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (grant[j]) idx = IW'(j);
    end
  end

  assign hit = |req;

  // R6
  always_comb begin
    if (!$isunknown(req)) begin
      grant_onehot_chk: assert ($onehot0(grant) && ((|grant) == hit));
    end
  end
endmodule

// File: rtl/irq_mask_flags.sv
module irq_mask_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_x,
  input  logic sw_i,
  input  logic ent_mask,
  input  logic ent_nmi,
  input  logic rti_en,
  input  logic rti_x,
  input  logic rti_i,
  output logic x_q,
  output logic i_q
);
  logic unl_q;
  logic x_d, i_d, unl_d, upd;

  assign upd = sw_wr | ent_mask | ent_nmi | rti_en;

  always_comb begin
    x_d = x_q;
    i_d = i_q;
    if (ent_nmi) begin
      x_d = 1'b1;
      i_d = 1'b1;
    end else if (ent_mask) begin
      i_d = 1'b1;
    end else if (rti_en) begin
      x_d = rti_x & ~unl_q;
      i_d = rti_i;
    end else if (sw_wr) begin
      x_d = x_q & sw_x;
      i_d = sw_i;
    end
    unl_d = unl_q | ~x_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= 1'b1;
      i_q   <= 1'b1;
      unl_q <= 1'b0;
    end else if (upd) begin
      x_q   <= x_d;
      i_q   <= i_d;
      unl_q <= unl_d;
    end
  end

  // R2
  x_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_q) |-> ($past(ent_nmi) || ($past(rti_en) && $past(rti_x))));
  // R2
  sw_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !ent_nmi && !ent_mask && !rti_en) |=> (!x_q || $past(x_q)));
  // R7
  ent_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_mask && !ent_nmi) |=> (i_q && (x_q == $past(x_q))));
  // R8
  ent_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_nmi |=> (x_q && i_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_mask_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned SRC_W   = $clog2(NUM_IRQ + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bnd,
  input  logic               trap_req,
  input  logic               nmi_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               x_flag,
  input  logic               i_flag,
  output logic               take_q,
  output logic [SRC_W-1:0]   src_q
);
  localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic          m_hit;
  logic [IW-1:0] m_idx;
  logic          elig;
  logic [SRC_W-1:0] win;

  irq_prio_enc #(.N(NUM_IRQ), .IW(IW)) u_enc (
    .req (irq_req),
    .hit (m_hit),
    .idx (m_idx)
  );

  always_comb begin
    elig = 1'b1;
    win  = SRC_W'(SRC_TRAP);
    if (trap_req) begin
      win = SRC_W'(SRC_TRAP);
    end else if (nmi_req && !x_flag) begin
      win = SRC_W'(SRC_NMI);
    end else if (m_hit && !i_flag) begin
      win = SRC_W'(m_idx) + SRC_W'(SRC_MASK_BASE);
    end else begin
      elig = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
    end else begin
      take_q <= bnd & elig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (bnd && elig) begin
      src_q <= win;
    end
  end

  // R10
  take_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(bnd));
  // R4
  trap_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && trap_req) |=> (take_q && src_q == SRC_W'(SRC_TRAP)));
  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && src_q >= SRC_W'(SRC_MASK_BASE)) |-> !$past(i_flag));
  // R5
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && src_q == SRC_W'(SRC_NMI)) |-> !$past(x_flag));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned SRC_W   = $clog2(NUM_IRQ + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_wr,
  input  logic               sw_x,
  input  logic               sw_i,
  input  logic               ent_mask,
  input  logic               ent_nmi,
  input  logic               rti_en,
  input  logic               rti_x,
  input  logic               rti_i,
  input  logic               bnd,
  input  logic               trap_req,
  input  logic               nmi_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  output logic               x_flag,
  output logic               i_flag,
  output logic               take,
  output logic [SRC_W-1:0]   src
);
  irq_mask_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr    (sw_wr),
    .sw_x     (sw_x),
    .sw_i     (sw_i),
    .ent_mask (ent_mask),
    .ent_nmi  (ent_nmi),
    .rti_en   (rti_en),
    .rti_x    (rti_x),
    .rti_i    (rti_i),
    .x_q      (x_flag),
    .i_q      (i_flag)
  );

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .bnd      (bnd),
    .trap_req (trap_req),
    .nmi_req  (nmi_req),
    .irq_req  (irq_req),
    .x_flag   (x_flag),
    .i_flag   (i_flag),
    .take_q   (take),
    .src_q    (src)
  );

  // R1
  rst_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !take);
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
  localparam int NI = 8;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr = 0, sw_x = 0, sw_i = 0, ent_mask = 0, ent_nmi = 0;
  logic rti_en = 0, rti_x = 0, rti_i = 0, bnd = 0, trap_req = 0, nmi_req = 0;
  logic [NI-1:0] irq_req = '0;
  logic x_flag, i_flag, take;
  logic [SW-1:0] src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic tk;
    logic [SW-1:0] sid;
    logic x;
    logic i;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  irq_mask_ctrl #(.NUM_IRQ(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_x(sw_x), .sw_i(sw_i),
    .ent_mask(ent_mask), .ent_nmi(ent_nmi), .rti_en(rti_en), .rti_x(rti_x),
    .rti_i(rti_i), .bnd(bnd), .trap_req(trap_req), .nmi_req(nmi_req),
    .irq_req(irq_req), .x_flag(x_flag), .i_flag(i_flag), .take(take), .src(src)
  );

  task automatic clear_in();
    sw_wr = 0; sw_x = 0; sw_i = 0; ent_mask = 0; ent_nmi = 0;
    rti_en = 0; rti_x = 0; rti_i = 0; bnd = 0; trap_req = 0;
    nmi_req = 0; irq_req = '0;
  endtask

  // inputs are already set; push the expectation for the next edge
  task automatic cyc(input logic tk, input logic [SW-1:0] sid,
                     input logic x, input logic i, input string tag);
    exp_t e;
    e.tk = tk; e.sid = sid; e.x = x; e.i = i; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    clear_in();
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (take !== e.tk || x_flag !== e.x || i_flag !== e.i ||
            (e.tk && src !== e.sid)) begin
          errors++;
          $display("FAIL %s: take=%0b src=%0d x=%0b i=%0b expected take=%0b src=%0d x=%0b i=%0b",
                   e.tag, take, src, x_flag, i_flag, e.tk, e.sid, e.x, e.i);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    checks++;
    if (x_flag !== 1'b1 || i_flag !== 1'b1 || take !== 1'b0) begin
      errors++;
      $display("FAIL R1: x=%0b i=%0b take=%0b expected x=1 i=1 take=0", x_flag, i_flag, take);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, 1, 1, "R1 after release");
    // everything masked except the trap
    bnd = 1; nmi_req = 1; irq_req = 8'hFF;
    cyc(0, 0, 1, 1, "R5 nmi masked by X, R6 masked by I");
    bnd = 1; trap_req = 1; nmi_req = 1;
    cyc(1, 0, 1, 1, "R4 trap unmasked");
    // clear I, try to set X (not yet unlocked, X stays 1)
    sw_wr = 1; sw_x = 1; sw_i = 0;
    cyc(0, 0, 1, 0, "R3 I write");
    bnd = 1; irq_req = 8'b0010_1000;
    cyc(1, 5, 1, 0, "R6 lowest index wins");
    irq_req = 8'hFF; nmi_req = 1;
    cyc(0, 0, 1, 0, "R10 no take without boundary");
    bnd = 1; nmi_req = 1; irq_req = 8'hFF;
    cyc(1, 2, 1, 0, "R5 masked nmi loses to line 0");
    sw_wr = 1; sw_x = 0; sw_i = 0;
    cyc(0, 0, 0, 0, "R2 clear X");
    bnd = 1; nmi_req = 1; irq_req = 8'h01;
    cyc(1, 1, 0, 0, "R5 nmi beats maskable");
    bnd = 1; trap_req = 1; nmi_req = 1; irq_req = 8'h01;
    cyc(1, 0, 0, 0, "R4 trap beats nmi");
    sw_wr = 1; sw_x = 1; sw_i = 1;
    cyc(0, 0, 0, 1, "R2 set X refused");
    bnd = 1; irq_req = 8'h80;
    cyc(0, 0, 0, 1, "R6 masked by I");
    ent_nmi = 1;
    cyc(0, 0, 1, 1, "R8 nmi entry");
    rti_en = 1; rti_x = 1; rti_i = 0;
    cyc(0, 0, 0, 0, "R9 restored X=1 refused");
    ent_mask = 1;
    cyc(0, 0, 0, 1, "R7 maskable entry");
    rti_en = 1; rti_x = 0; rti_i = 0;
    cyc(0, 0, 0, 0, "R9 restore I");
    ent_mask = 1; rti_en = 1; rti_i = 0; sw_wr = 1; sw_i = 0;
    cyc(0, 0, 0, 1, "R11 entry over return and write");
    rti_en = 1; rti_i = 1; sw_wr = 1; sw_i = 0;
    cyc(0, 0, 0, 1, "R11 return over write");
    sw_wr = 1; sw_x = 1; sw_i = 0;
    cyc(0, 0, 0, 0, "R3 I clear leaves X");
    bnd = 1; irq_req = 8'h80;
    cyc(1, 9, 0, 0, "R6 line 7 id 9");
    cyc(0, 0, 0, 0, "R10 single cycle");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule